// File: doc/BRIEF.md
# Halfword-Select Multiply-Accumulate Unit

This block is a 64-bit accumulator datapath. On each accepted operation it forms signed products from chosen elements of two 64-bit sources and either adds the result to the accumulator or subtracts it. In halfword mode each 32-bit word of a source gives one 16-bit element, either its lower or its upper half. The two element products are summed before they reach the accumulator. In word mode one whole 32-bit word of each source is chosen, and the single 32×32 product is applied.

The element choice is made separately for each source. A negate control picks subtraction. An operation is presented with `valid_in` for one cycle. The accumulator takes the result on that rising edge, and `valid_out` marks the cycle in which the new value can be read. A clear input empties the accumulator. When clear and an operation arrive together, the accumulator restarts from zero with that operation's result.

Top module: `hsmac_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `acc_out` becomes 0 and `valid_out` becomes 0.
- R2: In halfword mode (`word_mode`=0), a select bit of 0 takes 16-bit lanes 0 and 2 of that source (bits 15:0 and 47:32). A select bit of 1 takes lanes 1 and 3 (bits 31:16 and 63:48). The choice is independent for `src_a` (`a_top`) and `src_b` (`b_top`).
- R3: In halfword mode the delta is a1·b1 + a2·b2. Here a1/b1 are the elements taken from the lower word (bits 31:0) and a2/b2 those from the upper word (bits 63:32). All elements are signed two's complement, and the sum is sign-extended to 64 bits.
- R4: With `negate`=0 the delta is added to the accumulator. With `negate`=1 it is subtracted.
- R5: In word mode (`word_mode`=1), a select bit of 0 takes bits 31:0 of that source and 1 takes bits 63:32. The delta is the signed 64-bit product of the two chosen words.
- R6: All accumulator arithmetic wraps modulo 2^64, with no saturation.
- R7: With `valid_in` and `clr` both low, `acc_out` does not change.
- R8: With `clr`=1 and `valid_in`=0 at a rising edge, `acc_out` becomes 0.
- R9: With `clr`=1 and `valid_in`=1 at the same edge, `acc_out` becomes 0 plus the delta (or 0 minus the delta when `negate` is set).
- R10: `valid_out` is high during exactly the cycle after each edge at which `valid_in` was high. `acc_out` already holds the updated value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empties the accumulator (restart point when paired with valid_in) |
| valid_in | input | 1 | Operation present this cycle |
| word_mode | input | 1 | 0 = two 16×16 products, 1 = one 32×32 product |
| a_top | input | 1 | Element select for src_a (0 = lower, 1 = upper) |
| b_top | input | 1 | Element select for src_b (0 = lower, 1 = upper) |
| negate | input | 1 | 1 = subtract the delta, 0 = add it |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| acc_out | output | 64 | Accumulator value |
| valid_out | output | 1 | Accumulator was updated by an operation on the last edge |

## Verification
Clear and an accumulate operation can arrive in the same cycle. The bench provokes this by first loading a non-zero accumulator. It then raises `clr` together with `valid_in` in both the add and the negate variants. The result is judged against a reference accumulator that zeroes its base before applying the delta. A bench that dropped either the clear or the operation would differ from that reference. A further case raises `clr` without `valid_in` and expects a plain zero with `valid_out` low.

// File: rtl/hsmac_pkg.sv
package hsmac_pkg;
    localparam int unsigned ACC_W  = 64;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = WORD_W / 2;
    localparam int unsigned NWORD  = ACC_W / WORD_W;
    localparam int unsigned PROD_H = 2 * HALF_W;

    typedef enum logic {
        MODE_HALF = 1'b0,
        MODE_WORD = 1'b1
    } mac_mode_e;

    typedef struct packed {
        mac_mode_e mode;
        logic      a_top;
        logic      b_top;
        logic      neg;
    } mac_ctl_t;

    function automatic logic [ACC_W-1:0] widen_word(input logic [WORD_W-1:0] w);
        return {{(ACC_W-WORD_W){w[WORD_W-1]}}, w};
    endfunction

    function automatic logic [PROD_H-1:0] widen_half(input logic [HALF_W-1:0] h);
        return {{(PROD_H-HALF_W){h[HALF_W-1]}}, h};
    endfunction

    function automatic logic [ACC_W-1:0] widen_prod(input logic [PROD_H-1:0] p);
        return {{(ACC_W-PROD_H){p[PROD_H-1]}}, p};
    endfunction
endpackage

// File: rtl/hsmac_pick.sv
module hsmac_pick
    import hsmac_pkg::*;
(
    input  logic [ACC_W-1:0]  src,
    input  logic              top,
    output logic [HALF_W-1:0] half_o [NWORD],
    output logic [WORD_W-1:0] word_o
);
    localparam int unsigned IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1;

    for (genvar k = 0; k < NWORD; k++) begin : g_lane
        always_comb begin
            if (top)
                half_o[k] = src[k*WORD_W + HALF_W +: HALF_W];
            else
                half_o[k] = src[k*WORD_W +: HALF_W];
        end
    end

    logic [IDX_W-1:0] widx;
    assign widx = IDX_W'(top);

    always_comb begin
        word_o = '0;
        for (int k = 0; k < NWORD; k++) begin
            if (widx == IDX_W'(k))
                word_o = src[k*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/hsmac_mul.sv
module hsmac_mul
    import hsmac_pkg::*;
(
    input  mac_mode_e         mode,
    input  logic [HALF_W-1:0] a_half [NWORD],
    input  logic [HALF_W-1:0] b_half [NWORD],
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    output logic [ACC_W-1:0]  delta
);
    logic [PROD_H-1:0] hprod [NWORD];
    logic [ACC_W-1:0]  hsum;
    logic [ACC_W-1:0]  wprod;

    for (genvar k = 0; k < NWORD; k++) begin : g_hmul
        assign hprod[k] = widen_half(a_half[k]) * widen_half(b_half[k]);
    end

    always_comb begin
        hsum = '0;
        for (int k = 0; k < NWORD; k++)
            hsum = hsum + widen_prod(hprod[k]);
    end

    assign wprod = widen_word(a_word) * widen_word(b_word);

    always_comb begin
        unique case (mode)
            MODE_WORD: delta = wprod;
            default:   delta = hsum;
        endcase
    end
endmodule

// File: rtl/hsmac_acc.sv
module hsmac_acc
    import hsmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             vld,
    input  logic             neg,
    input  logic [ACC_W-1:0] delta,
    output logic [ACC_W-1:0] acc,
    output logic             vld_q
);
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] nxt;

    assign base = clr ? '0 : acc;
    assign nxt  = neg ? (base - delta) : (base + delta);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= vld;
            if (vld)
                acc <= nxt;
            else if (clr)
                acc <= '0;
        end
    end
endmodule

// File: rtl/hsmac_unit.sv
module hsmac_unit
    import hsmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              valid_in,
    input  logic              word_mode,
    input  logic              a_top,
    input  logic              b_top,
    input  logic              negate,
    input  logic [ACC_W-1:0]  src_a,
    input  logic [ACC_W-1:0]  src_b,
    output logic [ACC_W-1:0]  acc_out,
    output logic              valid_out
);
    mac_ctl_t          ctl;
    logic [HALF_W-1:0] a_half [NWORD];
    logic [HALF_W-1:0] b_half [NWORD];
    logic [WORD_W-1:0] a_word;
    logic [WORD_W-1:0] b_word;
    logic [ACC_W-1:0]  delta;

    assign ctl.mode  = word_mode ? MODE_WORD : MODE_HALF;
    assign ctl.a_top = a_top;
    assign ctl.b_top = b_top;
    assign ctl.neg   = negate;

    hsmac_pick u_pick_a (
        .src    (src_a),
        .top    (ctl.a_top),
        .half_o (a_half),
        .word_o (a_word)
    );

    hsmac_pick u_pick_b (
        .src    (src_b),
        .top    (ctl.b_top),
        .half_o (b_half),
        .word_o (b_word)
    );

    hsmac_mul u_mul (
        .mode   (ctl.mode),
        .a_half (a_half),
        .b_half (b_half),
        .a_word (a_word),
        .b_word (b_word),
        .delta  (delta)
    );

    hsmac_acc u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .vld   (valid_in),
        .neg   (ctl.neg),
        .delta (delta),
        .acc   (acc_out),
        .vld_q (valid_out)
    );
endmodule

// File: rtl/hsmac_chk.sv
module hsmac_chk
    import hsmac_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             valid_in,
    input logic             word_mode,
    input logic             a_top,
    input logic [ACC_W-1:0] src_a,
    input logic [ACC_W-1:0] acc_out,
    input logic             valid_out
);
    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (acc_out == '0) && !valid_out); // R1
    AST_LOW_LANES_ONLY: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !clr && !word_mode && !a_top && src_a[15:0] == '0 && src_a[47:32] == '0)
        |=> $stable(acc_out)); // R2
    AST_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !clr && word_mode && src_a == '0) |=> $stable(acc_out)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!valid_in && !clr) |=> $stable(acc_out)); // R7
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (clr && !valid_in) |=> (acc_out == '0)); // R8
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out); // R10
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out); // R10
endmodule

bind hsmac_unit hsmac_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .valid_in  (valid_in),
    .word_mode (word_mode),
    .a_top     (a_top),
    .src_a     (src_a),
    .acc_out   (acc_out),
    .valid_out (valid_out)
);

// File: tb/sim_hsmac_unit.sv
`timescale 1ns/1ps
module sim_hsmac_unit;
    logic        clk = 1'b0;
    logic        rst, clr, valid_in, word_mode, a_top, b_top, negate;
    logic [63:0] src_a, src_b, acc_out;
    logic        valid_out;
    logic [63:0] m_acc;
    int          errors = 0;
    int          checks = 0;

    always #5 clk = ~clk;

    hsmac_unit u0 (
        .clk(clk), .rst(rst), .clr(clr), .valid_in(valid_in),
        .word_mode(word_mode), .a_top(a_top), .b_top(b_top), .negate(negate),
        .src_a(src_a), .src_b(src_b), .acc_out(acc_out), .valid_out(valid_out)
    );

    // {word_mode, a_top, b_top, negate, src_a, src_b}
    localparam logic [131:0] VEC [10] = '{
        {4'b0000, 64'h0004_0003_0002_0001, 64'h0010_0020_0030_0040},   // R2 R3 low/low
        {4'b0110, 64'h0004_0003_0002_0001, 64'h0010_0020_0030_0040},   // R2 R3 high/high
        {4'b0100, 64'hFFFF_0005_7FFF_8000, 64'h0003_0007_0002_FFFE},   // R2 a high, b low
        {4'b0010, 64'hFFFF_0005_7FFF_8000, 64'h0003_0007_0002_FFFE},   // R2 a low, b high
        {4'b0001, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000},   // R4 negate halfword
        {4'b1000, 64'h0000_0001_FFFF_FFFF, 64'h1234_5678_0000_0003},   // R5 w0*w0
        {4'b1010, 64'h0000_0001_FFFF_FFFF, 64'h1234_5678_0000_0003},   // R5 w0*w1
        {4'b1100, 64'h0000_0001_FFFF_FFFF, 64'h1234_5678_0000_0003},   // R5 w1*w0
        {4'b1111, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},   // R5 R4 w1*w1 neg
        {4'b1001, 64'h7FFF_FFFF_0000_0000, 64'h0000_0000_7FFF_FFFF}    // R5 R4 w0*w0 neg
    };

    function automatic logic [63:0] ref_delta(input logic wm, input logic at, input logic bt,
                                              input logic [63:0] a, input logic [63:0] b);
        longint r;
        if (wm) begin
            logic signed [31:0] wa, wb;
            wa = at ? a[63:32] : a[31:0];
            wb = bt ? b[63:32] : b[31:0];
            r = longint'(wa) * longint'(wb);
        end else begin
            logic signed [15:0] a1, a2, b1, b2;
            a1 = at ? a[31:16] : a[15:0];
            a2 = at ? a[63:48] : a[47:32];
            b1 = bt ? b[31:16] : b[15:0];
            b2 = bt ? b[63:48] : b[47:32];
            r = longint'(a1) * longint'(b1) + longint'(a2) * longint'(b2);
        end
        return 64'(r);
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_op(input string req, input logic c, input logic wm, input logic at,
                         input logic bt, input logic ng, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] base, d;
        @(negedge clk);
        clr = c; valid_in = 1'b1; word_mode = wm; a_top = at; b_top = bt; negate = ng;
        src_a = a; src_b = b;
        base = c ? 64'd0 : m_acc;
        d = ref_delta(wm, at, bt, a, b);
        m_acc = ng ? base - d : base + d;
        @(negedge clk);
        clr = 1'b0; valid_in = 1'b0;
        check64(req, acc_out, m_acc);
        check1("R10 valid_out after op", valid_out, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; clr = 1'b0; valid_in = 1'b0; word_mode = 1'b0;
        a_top = 1'b0; b_top = 1'b0; negate = 1'b0; src_a = '0; src_b = '0;
        m_acc = '0;
        repeat (3) @(negedge clk);
        check64("R1 reset acc", acc_out, 64'd0);
        check1("R1 reset valid_out", valid_out, 1'b0);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < 10; i++) begin
            logic [131:0] v;
            v = VEC[i];
            do_op("R3 R4 R5 table", 1'b0, v[131], v[130], v[129], v[128], v[127:64], v[63:0]);
        end

        // R2: upper lanes only populated, low select -> no change
        do_op("R2 ignore upper lanes", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
              64'h7777_0000_5555_0000, 64'h1234_0001_4321_0001);

        // R7: idle cycles hold
        @(negedge clk);
        src_a = 64'hFFFF_FFFF_FFFF_FFFF; src_b = 64'h1;
        repeat (3) @(negedge clk);
        check64("R7 hold when idle", acc_out, m_acc);
        check1("R10 no valid when idle", valid_out, 1'b0);

        // R8: clear alone
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_acc = '0;
        check64("R8 clear", acc_out, 64'd0);
        check1("R8 clear no valid", valid_out, 1'b0);

        // R6: wrap below zero then back
        do_op("R6 wrap down", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h1, 64'h1);
        check64("R6 all ones", acc_out, 64'hFFFF_FFFF_FFFF_FFFF);
        do_op("R6 wrap up", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001);
        check64("R6 back to one", acc_out, 64'd1);

        // R9: clear with operation, add and negate variants
        do_op("R9 preload", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 64'd1000, 64'd1000);
        do_op("R9 clear+add", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'd7, 64'd6);
        check64("R9 restart value", acc_out, 64'd42);
        do_op("R9 clear+negate", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0003_0000_0002_0000, 64'h0005_0000_0004_0000);
        check64("R9 negative restart", acc_out, 64'hFFFF_FFFF_FFFF_FFE9);

        // random mixed sequence
        for (int i = 0; i < 40; i++) begin
            logic [31:0] r;
            r = $urandom;
            do_op("R3 R4 R5 random", 1'b0, r[0], r[1], r[2], r[3],
                  {$urandom, $urandom}, {$urandom, $urandom});
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule